// File: doc/BRIEF.md
# Dual-Port Command and Status Register Interface

This block is the byte-wide host-facing register interface of an Ethernet controller core. A single byte address is shared in time by two logical ports. The host picks the port with switch commands. In the main port, each command byte carries four things: an operation code, a channel bit, a status-read pointer and an interrupt-acknowledge bit. Legal operations go to the execution logic as a one-cycle decoded pulse. In the auxiliary port, command bytes enable or disable the interrupt output, request power-down, reset the interface, or load a 7-bit stop register.

The execution logic reports completed events through a single-cycle report strobe. The block captures each report into the main-port status bank and raises the interrupt. Reads return the status byte under the current pointer and then advance it. The pointer wraps at the end of the active bank. The main-port bank is four or six bytes long, chosen by a configuration pin. The auxiliary bank is three bytes long: power-down and high-impedance flags, the stop register, and the bus throttle timer. The host bus has no back-pressure. A write strobe is taken in the cycle it is high. A read strobe consumes the byte currently shown on the read data port.

Top module: `dpcs_host_if`

## Requirements
- R1: After hardware reset, the main port is selected (`port_sel`=0), `irq`=0, `power_down`=0, `stop_reg`=0, interrupts are enabled, and `rd_data` shows main-port byte 0, which reads 0x00.
- R2: A main-port write has the opcode in bits 3:0, the channel in bit 4, the pointer field in bits 6:5 and the acknowledge in bit 7. Opcodes 1 to 14 produce `cmd_valid` high for exactly the one cycle after the write edge, with `cmd_op` and `cmd_chnl` copied from the byte. Opcodes 0 and 15, and every auxiliary-port write, produce no pulse.
- R3: Main-port opcode 0 with channel 1 selects the auxiliary port (`port_sel`=1). Auxiliary opcode 1 with bit 7 clear selects the main port again.
- R4: Every command write, other than a stop-register load, sets the pointer from bits 6:5, using the bank of the port that is selected after the write. In the 4-byte main bank, field f gives byte f. The 4-byte order is STATUS0, result 1, result 2, STATUS3. In the 6-byte main bank (`cfg_six_byte`=1), fields 0/1/2/3 give bytes 0/1/3/5. The 6-byte order is STATUS0, result 1, result 2, count low, count high, STATUS3. In the auxiliary bank, fields 0/1/2 give STATUS4/5/6 and field 3 gives STATUS4.
- R5: Each read strobe without a write advances the pointer by one. The pointer wraps to byte 0 after the last byte of the active bank.
- R6: Main-port opcode 15 with channel 1 fixes the pointer, so reads stop advancing it. Opcode 15 with channel 0 releases it. Both still load the pointer field.
- R7: An event report captures the following into STATUS0: the receive flag into bit 6, the execute flag into bit 5, the channel into bit 4 and the code into bits 3:0. It captures the two result bytes and the 16-bit receive count at the same time. STATUS0 bit 7 is the INT flag. STATUS3 reads `unit_status` live, with bit 3 forced to 0.
- R8: An event report sets INT and drives `irq` high from the next cycle. A main-port write with bit 7 set clears INT and `irq`. An event report in the same cycle as an acknowledge wins.
- R9: Auxiliary opcode 2 forces `irq` low while INT is still recorded in STATUS0. Auxiliary opcode 3 re-enables `irq`, which then follows the recorded INT flag.
- R10: An auxiliary write with bit 7 set loads bits 6:0 into the stop register. The stop register drives `stop_reg` and STATUS5 bits 6:0. This write leaves the pointer unchanged.
- R11: Auxiliary opcode 8 sets `power_down`. STATUS4 is {2'b00, power-down, 4'b0000, `hiz_flag`}. STATUS6 is {`throttle_tc`, `throttle_val`}.
- R12: Opcode 14 in either port returns the interface to the R1 state: main port, pointer 0 unfixed, INT clear, interrupts enabled, stop register 0, power-down clear. In the main port it also issues the `cmd_valid` pulse with opcode 14.
- R13: When a write and a read strobe share a cycle, the write is taken and the read does not advance the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe; consumes the byte on rd_data |
| rd_data | output | 8 | Status byte under the current pointer |
| cfg_six_byte | input | 1 | 1 selects the 6-byte main status bank |
| cmd_valid | output | 1 | One-cycle decoded command pulse |
| cmd_op | output | 4 | Opcode of the pulsed command |
| cmd_chnl | output | 1 | Channel of the pulsed command |
| evt_valid | input | 1 | Event report strobe |
| evt_code | input | 4 | Event code |
| evt_chnl | input | 1 | Event channel |
| evt_rcv | input | 1 | Event came from the receive unit |
| evt_exec | input | 1 | Event came from the execution unit |
| evt_res1 | input | 8 | First result byte |
| evt_res2 | input | 8 | Second result byte |
| evt_count | input | 16 | Receive byte count |
| unit_status | input | 8 | Live unit states for STATUS3 |
| hiz_flag | input | 1 | High-impedance flag for STATUS4 |
| throttle_tc | input | 1 | Throttle terminal-count flag for STATUS6 |
| throttle_val | input | 7 | Throttle timer value for STATUS6 |
| port_sel | output | 1 | 0 main port, 1 auxiliary port |
| irq | output | 1 | Interrupt line |
| stop_reg | output | 7 | Stop register value |
| power_down | output | 1 | Power-down request |

## Verification
A pointer that is one byte wrong shows up on the very next read. A wrong wrap length only shows up once the bank has been walked past its last byte, so the bench walks every bank past its end in both main sizes. Port selection and interrupt-enable state are hidden bits: a bad one shows only through the byte a later read returns, or through `irq` after the next event. The bench therefore follows each mode change with an event or a read. A stale or lost INT flag shows on `irq` one cycle after the report or acknowledge, and again in STATUS0 bit 7.

// File: rtl/dpcs_pkg.sv
package dpcs_pkg;
  localparam int DW = 8;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_IA_CFG   = 4'd1,
    OP_CONFIG   = 4'd2,
    OP_MC_SET   = 4'd3,
    OP_XMIT     = 4'd4,
    OP_TDR      = 4'd5,
    OP_DUMP     = 4'd6,
    OP_DIAG     = 4'd7,
    OP_RX_ON    = 4'd8,
    OP_XMIT_RAW = 4'd9,
    OP_RX_OFF   = 4'd10,
    OP_RX_STOP  = 4'd11,
    OP_REXMIT   = 4'd12,
    OP_ABORT    = 4'd13,
    OP_RESET    = 4'd14,
    OP_PTR      = 4'd15
  } main_op_e;

  localparam logic [3:0] AUX_TO_MAIN = 4'd1;
  localparam logic [3:0] AUX_INT_OFF = 4'd2;
  localparam logic [3:0] AUX_INT_ON  = 4'd3;
  localparam logic [3:0] AUX_SLEEP   = 4'd8;
  localparam logic [3:0] AUX_RESET   = 4'd14;

  typedef struct packed {
    logic       pulse;
    logic [3:0] op;
    logic       chnl;
    logic       ack;
    logic       swap;
    logic       fix;
    logic       rls;
    logic       load_ptr;
    logic [1:0] pfield;
    logic       int_off;
    logic       int_on;
    logic       sleep;
    logic       soft_rst;
    logic       stop_ld;
  } dec_t;

  function automatic logic [2:0] bank_len(input logic aux, input logic six);
    if (aux)      return 3'd3;
    else if (six) return 3'd6;
    else          return 3'd4;
  endfunction

  function automatic logic [2:0] start_idx(input logic aux, input logic six,
                                           input logic [1:0] f);
    if (aux) return (f == 2'd3) ? 3'd0 : {1'b0, f};
    if (six) begin
      case (f)
        2'd0:    return 3'd0;
        2'd1:    return 3'd1;
        2'd2:    return 3'd3;
        default: return 3'd5;
      endcase
    end
    return {1'b0, f};
  endfunction

  function automatic logic [2:0] next_idx(input logic [2:0] cur,
                                          input logic [2:0] len);
    if (cur >= len - 3'd1) return 3'd0;
    return cur + 3'd1;
  endfunction
endpackage

// File: rtl/dpcs_decode.sv
module dpcs_decode
  import dpcs_pkg::*;
(
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          aux_sel,
  output dec_t          dec
);
  logic [3:0] op;
  logic       ch;
  logic       b7;

  assign op = wr_data[3:0];
  assign ch = wr_data[4];
  assign b7 = wr_data[7];

  always_comb begin
    dec        = '0;
    dec.op     = op;
    dec.chnl   = ch;
    dec.pfield = wr_data[6:5];
    if (wr_en) begin
      if (!aux_sel) begin
        dec.ack      = b7;
        dec.load_ptr = 1'b1;
        if (op == OP_NOP) begin
          dec.swap = ch;
        end else if (op == OP_PTR) begin
          dec.fix = ch;
          dec.rls = !ch;
        end else begin
          dec.pulse    = 1'b1;
          dec.soft_rst = (op == OP_RESET);
        end
      end else if (b7) begin
        dec.stop_ld = 1'b1;
      end else begin
        dec.load_ptr = 1'b1;
        case (op)
          AUX_TO_MAIN: dec.swap     = 1'b1;
          AUX_INT_OFF: dec.int_off  = 1'b1;
          AUX_INT_ON:  dec.int_on   = 1'b1;
          AUX_SLEEP:   dec.sleep    = 1'b1;
          AUX_RESET:   dec.soft_rst = 1'b1;
          default:     ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpcs_irq.sv
module dpcs_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic evt,
  input  logic ack,
  input  logic int_off,
  input  logic int_on,
  output logic int_flag,
  output logic int_en,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_flag <= 1'b0;
      int_en   <= 1'b1;
    end else if (soft_rst) begin
      int_flag <= 1'b0;
      int_en   <= 1'b1;
    end else begin
      if (evt)      int_flag <= 1'b1;
      else if (ack) int_flag <= 1'b0;
      if (int_off)     int_en <= 1'b0;
      else if (int_on) int_en <= 1'b1;
    end
  end

  assign irq = int_flag & int_en;
endmodule

// File: rtl/dpcs_status.sv
module dpcs_status
  import dpcs_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STOP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [3:0]        evt_code,
  input  logic              evt_chnl,
  input  logic              evt_rcv,
  input  logic              evt_exec,
  input  logic [DW-1:0]     evt_res1,
  input  logic [DW-1:0]     evt_res2,
  input  logic [CNT_W-1:0]  evt_count,
  input  logic [DW-1:0]     unit_status,
  input  logic              int_flag,
  input  logic              sleep_flag,
  input  logic              hiz_flag,
  input  logic [STOP_W-1:0] stop_val,
  input  logic              throttle_tc,
  input  logic [DW-2:0]     throttle_val,
  input  logic              aux_sel,
  input  logic              six,
  input  logic [2:0]        idx,
  output logic [DW-1:0]     rd_data
);
  localparam int NCB = (CNT_W + DW - 1) / DW;
  localparam int CPW = NCB * DW;

  logic [6:0]     s0_q;
  logic [DW-1:0]  r1_q, r2_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CPW-1:0] cnt_pad;
  logic [DW-1:0]  cnt_b [NCB];
  logic [DW-1:0]  main4 [4];
  logic [DW-1:0]  main6 [6];
  logic [DW-1:0]  auxb  [3];
  logic [DW-1:0]  s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q  <= '0;
      r1_q  <= '0;
      r2_q  <= '0;
      cnt_q <= '0;
    end else if (evt_valid) begin
      s0_q  <= {evt_rcv, evt_exec, evt_chnl, evt_code};
      r1_q  <= evt_res1;
      r2_q  <= evt_res2;
      cnt_q <= evt_count;
    end
  end

  assign cnt_pad = CPW'(cnt_q);
  for (genvar g = 0; g < NCB; g++) begin : g_cnt
    assign cnt_b[g] = cnt_pad[g*DW +: DW];
  end

  assign s3 = {unit_status[7:4], 1'b0, unit_status[2:0]};

  always_comb begin
    main4[0] = {int_flag, s0_q};
    main4[1] = r1_q;
    main4[2] = r2_q;
    main4[3] = s3;
    main6[0] = {int_flag, s0_q};
    main6[1] = r1_q;
    main6[2] = r2_q;
    main6[3] = cnt_b[0];
    main6[4] = (NCB > 1) ? cnt_b[NCB-1] : '0;
    main6[5] = s3;
    auxb[0]  = {2'b00, sleep_flag, 4'b0000, hiz_flag};
    auxb[1]  = DW'(stop_val);
    auxb[2]  = {throttle_tc, throttle_val};
  end

  always_comb begin
    rd_data = '0;
    if (aux_sel) begin
      if (idx < 3'd3) rd_data = auxb[idx[1:0]];
    end else if (six) begin
      if (idx < 3'd6) rd_data = main6[idx];
    end else begin
      rd_data = main4[idx[1:0]];
    end
  end
endmodule

// File: rtl/dpcs_host_if.sv
module dpcs_host_if
  import dpcs_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STOP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  input  logic              cfg_six_byte,
  output logic              cmd_valid,
  output logic [3:0]        cmd_op,
  output logic              cmd_chnl,
  input  logic              evt_valid,
  input  logic [3:0]        evt_code,
  input  logic              evt_chnl,
  input  logic              evt_rcv,
  input  logic              evt_exec,
  input  logic [7:0]        evt_res1,
  input  logic [7:0]        evt_res2,
  input  logic [CNT_W-1:0]  evt_count,
  input  logic [7:0]        unit_status,
  input  logic              hiz_flag,
  input  logic              throttle_tc,
  input  logic [6:0]        throttle_val,
  output logic              port_sel,
  output logic              irq,
  output logic [STOP_W-1:0] stop_reg,
  output logic              power_down
);
  dec_t       dec;
  logic [2:0] rd_idx;
  logic       ptr_fixed;
  logic       int_flag;
  logic       int_en_q;
  logic       port_nxt;
  logic [2:0] len_now;

  dpcs_decode u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .aux_sel (port_sel),
    .dec     (dec)
  );

  dpcs_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (dec.soft_rst),
    .evt      (evt_valid),
    .ack      (dec.ack),
    .int_off  (dec.int_off),
    .int_on   (dec.int_on),
    .int_flag (int_flag),
    .int_en   (int_en_q),
    .irq      (irq)
  );

  assign port_nxt = port_sel ^ dec.swap;
  assign len_now  = bank_len(port_sel, cfg_six_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_sel   <= 1'b0;
      rd_idx     <= '0;
      ptr_fixed  <= 1'b0;
      stop_reg   <= '0;
      power_down <= 1'b0;
    end else if (dec.soft_rst) begin
      port_sel   <= 1'b0;
      rd_idx     <= '0;
      ptr_fixed  <= 1'b0;
      stop_reg   <= '0;
      power_down <= 1'b0;
    end else begin
      port_sel <= port_nxt;
      if (dec.load_ptr)
        rd_idx <= start_idx(port_nxt, cfg_six_byte, dec.pfield);
      else if (rd_en && !wr_en && !ptr_fixed)
        rd_idx <= next_idx(rd_idx, len_now);
      if (dec.fix)      ptr_fixed <= 1'b1;
      else if (dec.rls) ptr_fixed <= 1'b0;
      if (dec.stop_ld) stop_reg <= wr_data[STOP_W-1:0];
      if (dec.sleep)   power_down <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_chnl  <= 1'b0;
    end else begin
      cmd_valid <= dec.pulse;
      if (dec.pulse) begin
        cmd_op   <= dec.op;
        cmd_chnl <= dec.chnl;
      end
    end
  end

  dpcs_status #(.CNT_W(CNT_W), .STOP_W(STOP_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_valid    (evt_valid),
    .evt_code     (evt_code),
    .evt_chnl     (evt_chnl),
    .evt_rcv      (evt_rcv),
    .evt_exec     (evt_exec),
    .evt_res1     (evt_res1),
    .evt_res2     (evt_res2),
    .evt_count    (evt_count),
    .unit_status  (unit_status),
    .int_flag     (int_flag),
    .sleep_flag   (power_down),
    .hiz_flag     (hiz_flag),
    .stop_val     (stop_reg),
    .throttle_tc  (throttle_tc),
    .throttle_val (throttle_val),
    .aux_sel      (port_sel),
    .six          (cfg_six_byte),
    .idx          (rd_idx),
    .rd_data      (rd_data)
  );
endmodule

// File: rtl/dpcs_host_if_chk.sv
module dpcs_host_if_chk #(
  parameter int STOP_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic              evt_valid,
  input logic              cmd_valid,
  input logic [3:0]        cmd_op,
  input logic              port_sel,
  input logic              irq,
  input logic [STOP_W-1:0] stop_reg,
  input logic              int_en,
  input logic              ptr_fixed,
  input logic [2:0]        rd_idx
);
  AST_CMD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(wr_en)); // R2
  AST_CMD_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != 4'd0 && cmd_op != 4'd15)); // R2
  AST_PORT_MOVES_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_sel) |-> $past(wr_en)); // R3
  AST_FIX_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_fixed && rd_en && !wr_en) |=> $stable(rd_idx)); // R6
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !port_sel && wr_data[7] && !evt_valid) |=> !irq); // R8
  AST_EVT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && int_en && !wr_en) |=> irq); // R8
  AST_MASK_SILENCES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq); // R9
  AST_STOP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(stop_reg)); // R10
  AST_RW_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && port_sel && wr_data[7]) |=> $stable(rd_idx)); // R13
endmodule

bind dpcs_host_if dpcs_host_if_chk #(.STOP_W(STOP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .evt_valid (evt_valid),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .port_sel  (port_sel),
  .irq       (irq),
  .stop_reg  (stop_reg),
  .int_en    (int_en_q),
  .ptr_fixed (ptr_fixed),
  .rd_idx    (rd_idx)
);

// File: tb/tb_dpcs_host_if.sv
module tb_dpcs_host_if;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic cfg_six_byte = 1'b0;
  logic cmd_valid, cmd_chnl;
  logic [3:0] cmd_op;
  logic evt_valid = 1'b0, evt_chnl = 1'b0, evt_rcv = 1'b0, evt_exec = 1'b0;
  logic [3:0] evt_code = '0;
  logic [7:0] evt_res1 = '0, evt_res2 = '0;
  logic [15:0] evt_count = '0;
  logic [7:0] unit_status = 8'hFF;
  logic hiz_flag = 1'b1, throttle_tc = 1'b1;
  logic [6:0] throttle_val = 7'h2A;
  logic port_sel, irq, power_down;
  logic [6:0] stop_reg;

  int vec = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpcs_host_if dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .cfg_six_byte(cfg_six_byte), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_chnl(cmd_chnl), .evt_valid(evt_valid),
    .evt_code(evt_code), .evt_chnl(evt_chnl), .evt_rcv(evt_rcv),
    .evt_exec(evt_exec), .evt_res1(evt_res1), .evt_res2(evt_res2),
    .evt_count(evt_count), .unit_status(unit_status), .hiz_flag(hiz_flag),
    .throttle_tc(throttle_tc), .throttle_val(throttle_val),
    .port_sel(port_sel), .irq(irq), .stop_reg(stop_reg), .power_down(power_down)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); v = rd_data; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic evt(input logic [3:0] c, input logic ch, input logic rc,
                     input logic ex, input logic [7:0] a, input logic [7:0] b,
                     input logic [15:0] n);
    @(negedge clk);
    evt_valid = 1'b1; evt_code = c; evt_chnl = ch; evt_rcv = rc; evt_exec = ex;
    evt_res1 = a; evt_res2 = b; evt_count = n;
    @(negedge clk); evt_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 port_sel", 16'(port_sel), 16'd0);
    chk("R1 irq", 16'(irq), 16'd0);
    chk("R1 power_down", 16'(power_down), 16'd0);
    chk("R1 stop_reg", 16'(stop_reg), 16'd0);
    chk("R1 rd_data", 16'(rd_data), 16'h00);
  endtask

  task automatic t_cmds();
    wr(8'h04);
    chk("R2 valid xmit", 16'(cmd_valid), 16'd1);
    chk("R2 op xmit", 16'(cmd_op), 16'd4);
    chk("R2 chnl0", 16'(cmd_chnl), 16'd0);
    @(negedge clk);
    chk("R2 one cycle", 16'(cmd_valid), 16'd0);
    wr(8'h18);
    chk("R2 op rx enable", 16'(cmd_op), 16'd8);
    chk("R2 chnl1", 16'(cmd_chnl), 16'd1);
    wr(8'h00);
    chk("R2 nop no pulse", 16'(cmd_valid), 16'd0);
  endtask

  task automatic t_event4();
    logic [7:0] v;
    cfg_six_byte = 1'b0;
    evt(4'd4, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h3C, 16'h0000);
    chk("R8 irq after event", 16'(irq), 16'd1);
    wr(8'h00);
    rd(v); chk("R7 status0", 16'(v), 16'hB4);
    rd(v); chk("R7 result1", 16'(v), 16'hA5);
    rd(v); chk("R7 result2", 16'(v), 16'h3C);
    rd(v); chk("R7 status3 bit3 zero", 16'(v), 16'hF7);
    rd(v); chk("R5 wrap 4-byte", 16'(v), 16'hB4);
  endtask

  task automatic t_six();
    logic [7:0] v;
    cfg_six_byte = 1'b1;
    evt(4'd8, 1'b0, 1'b1, 1'b0, 8'h11, 8'h22, 16'h1234);
    wr(8'h40);
    rd(v); chk("R4 six field2 count lo", 16'(v), 16'h34);
    rd(v); chk("R7 count hi", 16'(v), 16'h12);
    rd(v); chk("R5 six status3", 16'(v), 16'hF7);
    rd(v); chk("R5 wrap 6-byte", 16'(v), 16'hC8);
    wr(8'h60);
    rd(v); chk("R4 six field3", 16'(v), 16'hF7);
    cfg_six_byte = 1'b0;
    wr(8'h40);
    rd(v); chk("R4 four field2", 16'(v), 16'h22);
  endtask

  task automatic t_fix();
    logic [7:0] v;
    wr(8'h5F);
    chk("R6 fix no pulse", 16'(cmd_valid), 16'd0);
    for (int i = 0; i < 3; i++) begin
      rd(v); chk("R6 fixed pointer", 16'(v), 16'h22);
    end
    wr(8'h0F);
    rd(v); chk("R6 released s0", 16'(v), 16'hC8);
    rd(v); chk("R6 released advance", 16'(v), 16'h11);
  endtask

  task automatic t_ack();
    logic [7:0] v;
    wr(8'h80);
    chk("R8 ack drops irq", 16'(irq), 16'd0);
    rd(v); chk("R8 INT bit cleared", 16'(v), 16'h48);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h80;
    evt_valid = 1'b1; evt_code = 4'd3; evt_chnl = 1'b0; evt_rcv = 1'b0;
    evt_exec = 1'b0; evt_res1 = 8'h5A; evt_res2 = 8'h00; evt_count = '0;
    @(negedge clk);
    wr_en = 1'b0; evt_valid = 1'b0;
    chk("R8 event beats ack", 16'(irq), 16'd1);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h20; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    rd(v); chk("R13 read ignored on write", 16'(v), 16'h5A);
  endtask

  task automatic t_aux();
    logic [7:0] v;
    wr(8'h10);
    chk("R3 to aux", 16'(port_sel), 16'd1);
    chk("R2 switch no pulse", 16'(cmd_valid), 16'd0);
    rd(v); chk("R11 status4", 16'(v), 16'h01);
    wr(8'h85);
    chk("R10 stop_reg", 16'(stop_reg), 16'h05);
    chk("R2 aux no pulse", 16'(cmd_valid), 16'd0);
    rd(v); chk("R10 ptr kept status5", 16'(v), 16'h05);
    rd(v); chk("R11 status6", 16'(v), 16'hAA);
    rd(v); chk("R5 wrap aux", 16'(v), 16'h01);
    wr(8'h08);
    chk("R11 power_down", 16'(power_down), 16'd1);
    rd(v); chk("R11 status4 pwrdn", 16'(v), 16'h21);
    wr(8'h60);
    rd(v); chk("R4 aux field3", 16'(v), 16'h21);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(8'h02);
    chk("R9 disable", 16'(irq), 16'd0);
    evt(4'd2, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0);
    chk("R9 masked event", 16'(irq), 16'd0);
    wr(8'h01);
    chk("R3 back to main", 16'(port_sel), 16'd0);
    rd(v); chk("R9 INT recorded", 16'(v), 16'h82);
    wr(8'h10);
    wr(8'h03);
    chk("R9 enable", 16'(irq), 16'd1);
  endtask

  task automatic t_softrst();
    logic [7:0] v;
    wr(8'h0E);
    chk("R12 aux reset port", 16'(port_sel), 16'd0);
    chk("R12 aux reset irq", 16'(irq), 16'd0);
    chk("R12 aux reset pwrdn", 16'(power_down), 16'd0);
    chk("R12 aux reset stop", 16'(stop_reg), 16'd0);
    chk("R12 aux no pulse", 16'(cmd_valid), 16'd0);
    evt(4'd1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 16'h0);
    chk("R12 ints re-enabled", 16'(irq), 16'd1);
    wr(8'h4E);
    chk("R12 main reset pulse", 16'(cmd_valid), 16'd1);
    chk("R12 main reset op", 16'(cmd_op), 16'd14);
    chk("R12 main reset irq", 16'(irq), 16'd0);
    rd(v); chk("R12 pointer zero", 16'(v), 16'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmds();
    t_event4();
    t_six();
    t_fix();
    t_ack();
    t_aux();
    t_mask();
    t_softrst();
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < WDOG) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      vec++;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", n);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule